// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for the two-wire PHY management interface (MDC clock, bidirectional MDIO data). Software programs a clock-rate field and then writes a 32-bit command word. That word holds the start pattern, the opcode, the PHY address, the register address, the turnaround bits and 16 data bits. Writing it while the block is idle launches one management frame. The frame is a preamble of ones followed by the command word, sent most significant bit first.

For a read, the block releases MDIO from the turnaround onwards and captures the 16 bits the PHY returns into the low half of the command word. When the last bit has been clocked, a completion flag is raised in the event word. Software clears the flag by writing a one to its bit position.

Register access is a single write port with a 2-bit select: 0 is the command word, 1 is the event word and 2 is the rate word. The command word and the event word are always visible on output ports.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, MDIO output enable is low, the command word reads 0 and the event word reads 0.
- R2: A command write while idle starts a frame only if bits [31:30] are 01 and bits [29:28] are 01 (write) or 10 (read). Any other value is stored in the command word, and no frame is started.
- R3: During a frame, MDC is high and low for N clock cycles each, where N is the rate field (bits [6:1] of a rate write). A field of 0 acts as 1. The first MDC rise comes N cycles after the starting write edge.
- R4: A frame carries PRE_LEN ones, followed by command bits 31 down to 0, one bit per MDC period. The first bit is presented at the starting edge.
- R5: MDIO changes only at the start of a frame or together with a falling MDC edge. It is constant while MDC stays high.
- R6: A write frame keeps the output enable high for the whole frame. A read frame drops the enable from the first turnaround bit (frame bit PRE_LEN+14) to the end.
- R7: In a read frame, MDIO is sampled at each rising MDC edge of the 16 data bits, and each sample is stored into command bits 15 down to 0 in order. Bits [31:16] keep their written value.
- R8: At the falling MDC edge that closes the last bit, the frame ends. Event bit 23 is set in the same cycle, and MDC stays low with the output enable low afterwards.
- R9: Writing the event word with bit 23 set clears the flag, and writing it with bit 23 clear leaves the flag unchanged. A clear in the cycle the flag is being set loses to the set.
- R10: Command writes that arrive during a frame are dropped. They neither change the command word nor restart the frame.
- R11: The rate is latched when the frame starts. A rate write during a frame only affects later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 event, 2 rate |
| reg_wdata | input | 32 | Register write data |
| mii_data | output | 32 | Command word, including read-back data |
| mii_event | output | 32 | Event word; bit 23 is the completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is a software clear of the completion flag that lands in exactly the cycle the frame finishes. From the ports, that cycle is only known by counting MDC half periods. The bench's behavioural model tracks the elapsed clock count of the current frame. It raises the event-clear write at the negative edge just before the count reaches the frame length times twice the half period. A second awkward case is a rate write and a command write landing mid-frame. The bench issues both during a read frame, then measures the frame length in clock cycles, which must match the old rate.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32,
  parameter int SPD_W   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] mii_data,
  output logic [31:0] mii_event,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FRAME   = PRE_LEN + 32;
  localparam int BW      = $clog2(FRAME);
  localparam int HDR_END = PRE_LEN + 14;
  localparam int DAT_BEG = PRE_LEN + 16;
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_EVT = 2'd1;
  localparam logic [1:0] SEL_SPD = 2'd2;

  logic [31:0]      data_q;
  logic [SPD_W-1:0] spd_q, half_q, cnt;
  logic [BW-1:0]    bitn;
  logic             busy, mdc_q, evt;

  wire cmd_wr = reg_we && (reg_sel == SEL_CMD);
  wire op_ok  = (reg_wdata[31:30] == 2'b01) &&
                (reg_wdata[29:28] == 2'b01 || reg_wdata[29:28] == 2'b10);
  wire go     = cmd_wr && !busy && op_ok;
  wire tick   = busy && (cnt == half_q - 1'b1);
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire last   = fall && (bitn == BW'(FRAME - 1));
  wire is_rd  = (data_q[29:28] == 2'b10);
  wire [BW-1:0] rel = BW'(FRAME - 1) - bitn;

  assign mii_data  = data_q;
  assign mii_event = {8'b0, evt, 23'b0};
  assign mdc       = mdc_q;
  assign mdio_oe   = busy && !(is_rd && bitn >= BW'(HDR_END));
  assign mdio_o    = (!busy || bitn < BW'(PRE_LEN)) ? 1'b1 : data_q[rel[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      spd_q  <= '0;
      half_q <= SPD_W'(1);
      cnt    <= '0;
      bitn   <= '0;
      busy   <= 1'b0;
      mdc_q  <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_SPD) spd_q <= reg_wdata[SPD_W:1];
      if (go) begin
        data_q <= reg_wdata;
        busy   <= 1'b1;
        bitn   <= '0;
        cnt    <= '0;
        mdc_q  <= 1'b0;
        half_q <= (spd_q == '0) ? SPD_W'(1) : spd_q;
      end else if (cmd_wr && !busy) begin
        data_q <= reg_wdata;
      end else if (busy) begin
        if (tick) begin
          cnt   <= '0;
          mdc_q <= ~mdc_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (rise && is_rd && bitn >= BW'(DAT_BEG)) data_q[rel[4:0]] <= mdio_i;
        if (fall) begin
          if (last) busy <= 1'b0;
          else      bitn <= bitn + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                             evt <= 1'b0;
    else if (last)                                          evt <= 1'b1;
    else if (reg_we && reg_sel == SEL_EVT && reg_wdata[23]) evt <= 1'b0;
  end

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < half_q);

  p_mdio_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

  p_done_with_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt) |-> $fell(busy));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc_q && !mdio_oe));

  p_header_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q[31:16]));

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int PRE   = 32;
  localparam int FRAME = PRE + 32;

  logic        clk = 0, rst_n = 0, reg_we = 0, mdio_i = 1;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] mii_data, mii_event;
  logic        mdc, mdio_o, mdio_oe;

  mdio_master #(.PRE_LEN(PRE), .SPD_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mii_data(mii_data), .mii_event(mii_event),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit m_busy = 0, m_evt = 0, pre_busy, done;
  int m_k = 0, m_h = 1, m_spd = 0, ph, b;
  logic [31:0] m_data = 0;
  logic [15:0] phy_word = 16'hBEEF;
  logic p_mdc = 0, p_oe = 0, p_o = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  function automatic logic [31:0] mkf(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  // behavioural reference, advanced at each rising clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_evt = 0; m_k = 0; m_h = 1; m_spd = 0; m_data = 0;
    end else begin
      pre_busy = m_busy; done = 0;
      if (m_busy) begin
        m_k++;
        if (m_k % m_h == 0) begin
          ph = m_k / m_h;
          if (ph % 2 == 1) begin
            b = (ph - 1) / 2;
            if (m_data[29:28] == 2'b10 && b >= PRE + 16) m_data[FRAME-1-b] = mdio_i;
          end else begin
            b = ph / 2 - 1;
            if (b == FRAME - 1) begin m_busy = 0; done = 1; end
          end
        end
      end
      if (reg_we) begin
        if (reg_sel == 2'd0 && !pre_busy) begin
          m_data = reg_wdata;
          if (reg_wdata[31:30] == 2'b01 &&
              (reg_wdata[29:28] == 2'b01 || reg_wdata[29:28] == 2'b10)) begin
            m_busy = 1; m_k = 0; m_h = (m_spd == 0) ? 1 : m_spd;
          end
        end else if (reg_sel == 2'd1 && reg_wdata[23] && !done) m_evt = 0;
        else if (reg_sel == 2'd2) m_spd = int'(reg_wdata[6:1]);
      end
      if (done) m_evt = 1;
    end
  end

  // per-cycle comparison and PHY stimulus, away from the active edge
  always @(negedge clk) begin
    automatic int  eb  = m_k / (2 * m_h);
    automatic bit  rd  = (m_data[29:28] == 2'b10);
    automatic bit  emc = m_busy ? ((m_k / m_h) % 2 == 1) : 1'b0;
    automatic bit  eoe = m_busy && !(rd && eb >= PRE + 14);
    automatic bit  eo  = (eb < PRE) ? 1'b1 : m_data[FRAME-1-eb];
    if (rst_n) begin
      chk("R3 mdc", {31'b0, mdc}, {31'b0, emc});
      chk("R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, eoe});
      if (eoe) chk("R4 mdio_o", {31'b0, mdio_o}, {31'b0, eo});
      if (mdc && p_mdc && mdio_oe && p_oe) chk("R5 mdio hold", {31'b0, mdio_o}, {31'b0, p_o});
      chk("R7 mii_data", mii_data, m_data);
      chk("R9 mii_event", mii_event, {8'b0, m_evt, 23'b0});
    end
    p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
    if (m_busy && rd && eb >= PRE + 16) mdio_i = phy_word[FRAME-1-eb];
    else mdio_i = 1'($urandom);
  end

  always @(posedge clk) if (cyc > 150000) begin
    nerr++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finish_run();
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 mdc", {31'b0, mdc}, 0);
    chk("R1 oe", {31'b0, mdio_oe}, 0);
    chk("R1 data", mii_data, 0);
    chk("R1 event", mii_event, 0);
    rst_n = 1;

    // R4 R6: write frame at rate 2
    wr(2'd2, 32'd2 << 1);
    wr(2'd0, mkf(2'b01, 5'd5, 5'd3, 16'hA5C3));
    wait_idle();
    chk("R8 event set", mii_event, 32'h0080_0000);
    chk("R8 mdc low", {31'b0, mdc}, 0);

    // R9: write of 0 keeps flag, write of bit 23 clears
    wr(2'd1, 32'h0);
    chk("R9 no clear", mii_event, 32'h0080_0000);
    wr(2'd1, 32'h0080_0000);
    chk("R9 clear", mii_event, 0);

    // R2: invalid start pattern only stored
    wr(2'd0, 32'h0000_1234);
    repeat (20) @(negedge clk);
    chk("R2 stored", mii_data, 32'h0000_1234);
    chk("R2 no frame", {31'b0, mdio_oe}, 0);
    wr(2'd0, {2'b01, 2'b11, 28'h0});
    repeat (10) @(negedge clk);
    chk("R2 bad opcode", {31'b0, mdio_oe}, 0);

    // R7 R10 R11: read at rate 3, mid-frame rate and command writes
    wr(2'd2, 32'd3 << 1);
    phy_word = 16'h1E2D;
    wr(2'd0, mkf(2'b10, 5'd17, 5'd1, 16'h0));
    wr(2'd2, 32'd1 << 1);
    wr(2'd0, mkf(2'b01, 5'd2, 5'd2, 16'hFFFF));
    n = 4;
    while (!mii_event[23]) begin @(negedge clk); n++; end
    chk("R11 frame length", n, 2 * 3 * FRAME);
    chk("R7 read data", mii_data, mkf(2'b10, 5'd17, 5'd1, 16'h1E2D));
    chk("R10 header kept", mii_data[31:16], mkf(2'b10, 5'd17, 5'd1, 16'h0) >> 16);
    wr(2'd1, 32'h0080_0000);

    // R3: rate field 0 acts as 1, read with different PHY data
    wr(2'd2, 32'h0);
    phy_word = 16'h8001;
    wr(2'd0, mkf(2'b10, 5'd0, 5'd31, 16'h0));
    wait_idle();
    chk("R3 fast read", mii_data[15:0], 16'h8001);

    // R9: clear coinciding with completion loses
    wr(2'd1, 32'h0080_0000);
    wr(2'd2, 32'd2 << 1);
    wr(2'd0, mkf(2'b01, 5'd9, 5'd4, 16'h0F0F));
    while (!(m_busy && m_k == 2 * m_h * FRAME - 1)) @(negedge clk);
    reg_we = 1; reg_sel = 2'd1; reg_wdata = 32'h0080_0000;
    @(negedge clk); reg_we = 0;
    chk("R9 set wins", mii_event, 32'h0080_0000);
    wr(2'd1, 32'h0080_0000);
    chk("R9 later clear", mii_event, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule